// File: doc/BRIEF.md
# Chained Burst DMA Sequencer

This block runs one direct-memory transfer at a time between system memory and a peripheral bus. The processor starts it with a single-beat command on a simplified system-bus port. The command carries an address that the processor has already translated. A 4-bit resource tag, formed from the command's burst flag and size lines, selects this block. The command's address does not choose a target. It becomes the start address of the transfer.

The sequencer cuts each elementary block into 32-byte bursts. It offers one burst at a time on a valid/ready port, so the memory side can let other traffic in between bursts. In extended mode it runs several blocks in a row. The base address of each block is the previous base plus a programmed increment. One interrupt pulse marks the end of the whole chain.

Some events stop the run and record a cause code and a fault address:
- a translation-sync notice,
- a second start while busy,
- a bad setup,
- a block that would cross a 4 KB page.

Software can restart the transfer from the recorded fault address.

Top module: `dma_chain_seq`

## Requirements
- R1: A command pulse (`cmd_valid`) is a hit only when {`cmd_tbst`,`cmd_tsiz`} equals the resource tag held in control bits 11:8. A non-hit has no effect on any output.
- R2: A hit while idle with a valid setup sets `busy` at the next edge. It also offers the first burst at the command address. Each block gives length/32 bursts at addresses stepping by 32. `bq_dir` holds the command's `cmd_write` value for the whole run (1 = memory to peripheral).
- R3: Burst port back-pressure: while `bq_valid` is high and `bq_ready` is low, `bq_valid` stays high and `bq_addr` holds. A burst is moved at an edge where both are high. Only one burst is outstanding at a time.
- R4: When control bit 0 (extended mode) is set, the run has as many blocks as the iteration register holds. Block k starts at the start address plus k times the increment. When bit 0 is clear, exactly one block runs, whatever the iteration register holds.
- R5: A full run ends at the edge that moves its final burst. At that edge `busy` falls, `done` rises and `irq` pulses for exactly one cycle. There is no pulse between chained blocks, and `done` never coexists with a nonzero cause.
- R6: `tlb_sync` while busy stops the run only when the offered burst is moved. After the stop, cause = 1 and `fault_addr` = the address the next burst would have used. `tlb_sync` while idle is ignored.
- R7: A hit while idle with a bad setup starts nothing and sets cause = 2 and `fault_addr` = the command address. A bad setup is any of:
  - length 0,
  - length above 4096,
  - length not a multiple of 32,
  - command address not 32-byte aligned,
  - extended mode with an iteration count of 0.
- R8: A hit while busy is a double start. It stops the run like R6, but with cause = 3. If both happen in one cycle, the sync notice wins.
- R9: A block whose base offset within its 4 KB page plus the length exceeds 4096 is never started. The run ends with cause = 4 and `fault_addr` = that block's base. This check applies at the start and at each chained block.
- R10: Writing config select 4 while idle clears `done` and the cause code. A started run also clears both.
- R11: Config writes (`cfg_we`) use `cfg_sel`:
  - 0 = control (bits 11:8 tag, bit 0 extended mode),
  - 1 = length in bytes (bits 12:0),
  - 2 = block increment,
  - 3 = iteration count (bits 15:0).

  Length, increment and iteration count are taken at the start of a run. Cause code encoding is 0 none, 1 sync, 2 setup, 3 double, 4 page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Single-beat initiating command present |
| cmd_write | input | 1 | Command is write type (sets direction) |
| cmd_tbst | input | 1 | Burst flag, top bit of resource tag |
| cmd_tsiz | input | 3 | Size lines, low bits of resource tag |
| cmd_addr | input | 32 | Translated start address |
| tlb_sync | input | 1 | Translation-sync notice seen on the system bus |
| bq_valid | output | 1 | Burst request offered |
| bq_ready | input | 1 | Burst accepted and moved |
| bq_addr | output | 32 | Address of offered burst |
| bq_dir | output | 1 | 1 = memory to peripheral |
| irq | output | 1 | One-cycle end-of-chain interrupt |
| busy | output | 1 | Transfer running |
| done | output | 1 | Sticky successful completion |
| abort_code | output | 3 | Sticky stop cause |
| fault_addr | output | 32 | Restart address after a stop |

## Verification
The bench holds the burst port stalled while a sync notice or second start arrives. A design that stops at once would drop a burst that was already offered, or record the wrong restart address. A chained run whose second block crosses a page must end after the first block with the second block's base recorded, not finish or wrap. Multi-block runs with a toggling ready must pulse `irq` exactly once. Each setup fault (zero, oversize, odd length, misaligned address, zero iterations) must start nothing. Clearing the mode bit must ignore a nonzero iteration count.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int RID_W = 4;
  typedef enum logic [2:0] {
    ABT_NONE   = 3'd0,
    ABT_TLB    = 3'd1,
    ABT_SETUP  = 3'd2,
    ABT_DOUBLE = 3'd3,
    ABT_PAGE   = 3'd4
  } abort_e;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int ITER_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_sel,
  input  logic [31:0]              cfg_wdata,
  output logic [dma_seq_pkg::RID_W-1:0] rid,
  output logic                     ext_en,
  output logic [LEN_W-1:0]         len_cfg,
  output logic [ADDR_W-1:0]        inc_cfg,
  output logic [ITER_W-1:0]        iter_cfg,
  output logic                     status_clr
);
  // R11 select map
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rid      <= '0;
      ext_en   <= 1'b0;
      len_cfg  <= '0;
      inc_cfg  <= '0;
      iter_cfg <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: begin
          rid    <= cfg_wdata[11:8];
          ext_en <= cfg_wdata[0];
        end
        3'd1: len_cfg  <= cfg_wdata[LEN_W-1:0];
        3'd2: inc_cfg  <= cfg_wdata[ADDR_W-1:0];
        3'd3: iter_cfg <= cfg_wdata[ITER_W-1:0];
        default: ;
      endcase
    end
  end

  assign status_clr = cfg_we && (cfg_sel == 3'd4);
endmodule

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode #(
  parameter int LEN_W   = 13,
  parameter int ITER_W  = 16,
  parameter int BURST_W = 5,
  parameter int PAGE_W  = 12
) (
  input  logic                     cmd_valid,
  input  logic                     cmd_tbst,
  input  logic [2:0]               cmd_tsiz,
  input  logic [dma_seq_pkg::RID_W-1:0] rid,
  input  logic [BURST_W-1:0]       addr_lo,
  input  logic [LEN_W-1:0]         len_cfg,
  input  logic                     ext_en,
  input  logic [ITER_W-1:0]        iter_cfg,
  output logic                     cmd_hit,
  output logic                     setup_bad
);
  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(1 << PAGE_W);

  // R1 resource tag match
  assign cmd_hit = cmd_valid && ({cmd_tbst, cmd_tsiz} == rid);

  // R7 setup screening
  assign setup_bad = (len_cfg == '0) || (len_cfg > PAGE_LEN) ||
                     (len_cfg[BURST_W-1:0] != '0) || (addr_lo != '0) ||
                     (ext_en && (iter_cfg == '0));
endmodule

// File: rtl/dma_page_chk.sv
module dma_page_chk #(
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 13
) (
  input  logic [PAGE_W-1:0] page_off,
  input  logic [LEN_W-1:0]  len,
  output logic              crosses
);
  localparam int SUM_W = LEN_W + 1;
  localparam logic [SUM_W-1:0] PAGE_LEN = SUM_W'(1 << PAGE_W);
  logic [SUM_W-1:0] end_off;

  assign end_off = SUM_W'(page_off) + SUM_W'(len);
  assign crosses = end_off > PAGE_LEN;
endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 13,
  parameter int ITER_W  = 16,
  parameter int BURST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              setup_bad,
  input  logic              start_cross,
  input  logic              chain_cross,
  input  logic              tlb_sync,
  input  logic              status_clr,
  input  logic              ext_en,
  input  logic [LEN_W-1:0]  len_cfg,
  input  logic [ADDR_W-1:0] inc_cfg,
  input  logic [ITER_W-1:0] iter_cfg,
  input  logic              bq_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] bq_addr,
  output logic              bq_dir,
  output logic [ADDR_W-1:0] next_base,
  output logic [LEN_W-1:0]  len_q,
  output logic              irq,
  output logic              done,
  output logic [2:0]        abort_code,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam logic [LEN_W-1:0]  BURST_LEN  = LEN_W'(1 << BURST_W);
  localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(1 << BURST_W);

  logic [ADDR_W-1:0] base_q, inc_q, next_addr;
  logic [LEN_W-1:0]  remain_q;
  logic [ITER_W-1:0] iter_left;
  logic              pend_q, ack, last_burst, last_iter;
  abort_e            cause_q, pend_code, evt_code, stop_code;

  assign ack        = busy && bq_ready;
  assign last_burst = (remain_q == BURST_LEN);
  assign last_iter  = (iter_left == ITER_W'(1));
  assign next_base  = base_q + inc_q;
  assign next_addr  = last_burst ? next_base : (bq_addr + BURST_STEP);
  // R8: sync notice outranks a double start in the same cycle
  assign evt_code   = tlb_sync ? ABT_TLB : (cmd_hit ? ABT_DOUBLE : ABT_NONE);
  assign stop_code  = pend_q ? pend_code : evt_code;
  assign abort_code = cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      bq_addr    <= '0;
      bq_dir     <= 1'b0;
      base_q     <= '0;
      inc_q      <= '0;
      len_q      <= '0;
      remain_q   <= '0;
      iter_left  <= '0;
      pend_q     <= 1'b0;
      pend_code  <= ABT_NONE;
      cause_q    <= ABT_NONE;
      fault_addr <= '0;
      done       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!busy) begin
        if (cmd_hit) begin
          done <= 1'b0;
          if (setup_bad) begin
            cause_q    <= ABT_SETUP;
            fault_addr <= cmd_addr;
          end else if (start_cross) begin
            cause_q    <= ABT_PAGE;
            fault_addr <= cmd_addr;
          end else begin
            cause_q   <= ABT_NONE;
            busy      <= 1'b1;
            bq_addr   <= cmd_addr;
            base_q    <= cmd_addr;
            bq_dir    <= cmd_write;
            len_q     <= len_cfg;
            remain_q  <= len_cfg;
            inc_q     <= inc_cfg;
            iter_left <= ext_en ? iter_cfg : ITER_W'(1);
            pend_q    <= 1'b0;
          end
        end else if (status_clr) begin
          done    <= 1'b0;
          cause_q <= ABT_NONE;
        end
      end else if (ack) begin
        if (stop_code != ABT_NONE) begin
          busy       <= 1'b0;
          cause_q    <= stop_code;
          fault_addr <= next_addr;
          pend_q     <= 1'b0;
        end else if (last_burst && last_iter) begin
          busy <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end else if (last_burst && chain_cross) begin
          busy       <= 1'b0;
          cause_q    <= ABT_PAGE;
          fault_addr <= next_base;
        end else if (last_burst) begin
          bq_addr   <= next_base;
          base_q    <= next_base;
          remain_q  <= len_q;
          iter_left <= iter_left - ITER_W'(1);
        end else begin
          bq_addr  <= bq_addr + BURST_STEP;
          remain_q <= remain_q - BURST_LEN;
        end
      end else if ((evt_code != ABT_NONE) && !pend_q) begin
        pend_q    <= 1'b1;
        pend_code <= evt_code;
      end
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 12,
  parameter int BURST_W = 5,
  parameter int ITER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_tbst,
  input  logic [2:0]        cmd_tsiz,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              tlb_sync,
  output logic              bq_valid,
  input  logic              bq_ready,
  output logic [ADDR_W-1:0] bq_addr,
  output logic              bq_dir,
  output logic              irq,
  output logic              busy,
  output logic              done,
  output logic [2:0]        abort_code,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int LEN_W = PAGE_W + 1;

  logic [dma_seq_pkg::RID_W-1:0] rid;
  logic              ext_en, status_clr, cmd_hit, setup_bad;
  logic              start_cross, chain_cross;
  logic [LEN_W-1:0]  len_cfg, len_q;
  logic [ADDR_W-1:0] inc_cfg, next_base;
  logic [ITER_W-1:0] iter_cfg;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ITER_W(ITER_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rid(rid), .ext_en(ext_en), .len_cfg(len_cfg),
    .inc_cfg(inc_cfg), .iter_cfg(iter_cfg), .status_clr(status_clr));

  dma_cmd_decode #(.LEN_W(LEN_W), .ITER_W(ITER_W), .BURST_W(BURST_W),
                   .PAGE_W(PAGE_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_tbst(cmd_tbst), .cmd_tsiz(cmd_tsiz),
    .rid(rid), .addr_lo(cmd_addr[BURST_W-1:0]), .len_cfg(len_cfg),
    .ext_en(ext_en), .iter_cfg(iter_cfg), .cmd_hit(cmd_hit),
    .setup_bad(setup_bad));

  // R9 page screening for the first block and for each chained block
  dma_page_chk #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_pg_start (
    .page_off(cmd_addr[PAGE_W-1:0]), .len(len_cfg), .crosses(start_cross));

  dma_page_chk #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_pg_chain (
    .page_off(next_base[PAGE_W-1:0]), .len(len_q), .crosses(chain_cross));

  dma_burst_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ITER_W(ITER_W),
                     .BURST_W(BURST_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .setup_bad(setup_bad), .start_cross(start_cross),
    .chain_cross(chain_cross), .tlb_sync(tlb_sync), .status_clr(status_clr),
    .ext_en(ext_en), .len_cfg(len_cfg), .inc_cfg(inc_cfg),
    .iter_cfg(iter_cfg), .bq_ready(bq_ready), .busy(busy),
    .bq_addr(bq_addr), .bq_dir(bq_dir), .next_base(next_base),
    .len_q(len_q), .irq(irq), .done(done), .abort_code(abort_code),
    .fault_addr(fault_addr));

  assign bq_valid = busy;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int BURST_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bq_valid,
  input logic              bq_ready,
  input logic [ADDR_W-1:0] bq_addr,
  input logic              bq_dir,
  input logic              irq,
  input logic              busy,
  input logic              done,
  input logic [2:0]        abort_code
);
  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bq_valid && !bq_ready) |=> (bq_valid && $stable(bq_addr) && $stable(bq_dir)));

  // R2
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bq_valid |-> (bq_addr[BURST_W-1:0] == '0));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && done));

  // R5
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (abort_code == 3'd0));

  // R6
  stop_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bq_ready));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_code != 3'd0) |-> !busy);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bq_valid(bq_valid), .bq_ready(bq_ready),
  .bq_addr(bq_addr), .bq_dir(bq_dir), .irq(irq), .busy(busy), .done(done),
  .abort_code(abort_code));

// File: tb/dma_chain_seq_tb.sv
module dma_chain_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, cmd_valid = 1'b0, cmd_write = 1'b0;
  logic        cmd_tbst = 1'b0, tlb_sync = 1'b0, bq_ready = 1'b0;
  logic [2:0]  cfg_sel = '0, cmd_tsiz = '0;
  logic [31:0] cfg_wdata = '0, cmd_addr = '0;
  logic        bq_valid, bq_dir, irq, busy, done;
  logic [31:0] bq_addr, fault_addr;
  logic [2:0]  abort_code;

  int n_chk = 0, n_err = 0, n_ack = 0, n_irq = 0, cyc = 0, rdy_mode = 0;
  bit finished = 1'b0;

  dma_chain_seq dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_irq, m_done, m_pend, m_ext, m_dir;
  int          m_code, m_pcode, m_len, s_len, m_iter, s_n, m_k, m_off;
  logic [31:0] m_fault, m_inc, s_inc, s_start;
  logic [3:0]  m_rid;

  function automatic logic [31:0] blk_base(input int k);
    return s_start + 32'(k) * s_inc;
  endfunction

  function automatic bit page_over(input logic [31:0] a, input int len);
    return (int'(a[11:0]) + len) > 4096;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_done = 0; m_pend = 0; m_ext = 0; m_dir = 0;
      m_code = 0; m_pcode = 0; m_len = 0; m_iter = 0; m_inc = '0; m_rid = '0;
      m_fault = '0;
    end else begin
      bit hit;
      int ev;
      hit = cmd_valid && ({cmd_tbst, cmd_tsiz} == m_rid);
      m_irq = 0;
      if (!m_busy) begin
        if (hit) begin
          m_done = 0;
          if (m_len == 0 || m_len > 4096 || (m_len % 32) != 0 ||
              cmd_addr[4:0] != 0 || (m_ext && m_iter == 0)) begin
            m_code = 2; m_fault = cmd_addr;
          end else if (page_over(cmd_addr, m_len)) begin
            m_code = 4; m_fault = cmd_addr;
          end else begin
            m_code = 0; m_busy = 1; s_start = cmd_addr; s_len = m_len;
            s_inc = m_inc; s_n = m_ext ? m_iter : 1; m_k = 0; m_off = 0;
            m_dir = cmd_write; m_pend = 0;
          end
        end else if (cfg_we && cfg_sel == 3'd4) begin
          m_done = 0; m_code = 0;
        end
      end else begin
        ev = tlb_sync ? 1 : (hit ? 3 : 0);
        if (bq_ready) begin
          int stop;
          bit lastb;
          logic [31:0] nxt;
          stop  = m_pend ? m_pcode : ev;
          lastb = (m_off + 32 == s_len);
          nxt   = lastb ? blk_base(m_k + 1) : blk_base(m_k) + 32'(m_off + 32);
          if (stop != 0) begin
            m_busy = 0; m_code = stop; m_fault = nxt; m_pend = 0;
          end else if (lastb && m_k + 1 == s_n) begin
            m_busy = 0; m_done = 1; m_irq = 1;
          end else if (lastb && page_over(nxt, s_len)) begin
            m_busy = 0; m_code = 4; m_fault = nxt;
          end else if (lastb) begin
            m_k++; m_off = 0;
          end else begin
            m_off += 32;
          end
        end else if (ev != 0 && !m_pend) begin
          m_pend = 1; m_pcode = ev;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: begin m_rid = cfg_wdata[11:8]; m_ext = cfg_wdata[0]; end
          3'd1: m_len  = int'(cfg_wdata[12:0]);
          3'd2: m_inc  = cfg_wdata;
          3'd3: m_iter = int'(cfg_wdata[15:0]);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 busy", 32'(busy), 32'(m_busy));
      chk("R3 bq_valid", 32'(bq_valid), 32'(m_busy));
      if (m_busy) begin
        chk("R2 bq_addr", bq_addr, blk_base(m_k) + 32'(m_off));
        chk("R2 bq_dir", 32'(bq_dir), 32'(m_dir));
      end
      chk("R5 irq", 32'(irq), 32'(m_irq));
      chk("R5 done", 32'(done), 32'(m_done));
      chk("R7 abort_code", 32'(abort_code), 32'(m_code));
      chk("R6 fault_addr", fault_addr, m_fault);
    end
  end

  // ready pattern: 0 always high, 1 alternating, 2 held low
  always @(negedge clk)
    bq_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;

  always @(posedge clk) begin
    if (rst_n && bq_valid && bq_ready) n_ack++;
    if (rst_n && irq) n_irq++;
  end

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send_cmd(input logic [3:0] tag, input logic [31:0] a, input bit wr);
    @(negedge clk);
    cmd_valid = 1'b1; {cmd_tbst, cmd_tsiz} = tag; cmd_addr = a; cmd_write = wr;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic pulse_tlb();
    @(negedge clk); tlb_sync = 1'b1;
    @(negedge clk); tlb_sync = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  int a0, i0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset busy", 32'(busy), 32'd0);
    chk("R7 reset code", 32'(abort_code), 32'd0);
    chk("R5 reset done", 32'(done), 32'd0);

    // R11 map: tag 5, length 128, single block
    cfg_wr(3'd0, 32'h0000_0500);
    cfg_wr(3'd1, 32'd128);
    cfg_wr(3'd3, 32'd3);
    // R1: mismatched tag ignored
    send_cmd(4'd3, 32'h1000_0040, 1'b1);
    chk("R1 mismatched tag busy", 32'(busy), 32'd0);
    chk("R1 mismatched tag code", 32'(abort_code), 32'd0);

    // R2, R5: single block of 4 bursts
    a0 = n_ack; i0 = n_irq;
    send_cmd(4'd5, 32'h1000_0040, 1'b1);
    chk("R2 busy after start", 32'(busy), 32'd1);
    wait_idle();
    @(negedge clk);
    chk("R2 burst count", 32'(n_ack - a0), 32'd4);
    chk("R5 one irq", 32'(n_irq - i0), 32'd1);
    chk("R5 done set", 32'(done), 32'd1);

    // R4, R3: extended chain of 3 blocks with alternating ready
    cfg_wr(3'd0, 32'h0000_0501);
    cfg_wr(3'd1, 32'd64);
    cfg_wr(3'd2, 32'h0000_0200);
    rdy_mode = 1;
    a0 = n_ack; i0 = n_irq;
    send_cmd(4'd5, 32'h2000_0000, 1'b0);
    wait_idle();
    @(negedge clk);
    chk("R4 chained bursts", 32'(n_ack - a0), 32'd6);
    chk("R5 single irq for chain", 32'(n_irq - i0), 32'd1);

    // R4: mode bit clear ignores iteration count
    cfg_wr(3'd0, 32'h0000_0500);
    rdy_mode = 0;
    a0 = n_ack; i0 = n_irq;
    send_cmd(4'd5, 32'h2000_1000, 1'b1);
    wait_idle();
    @(negedge clk);
    chk("R4 one block when not extended", 32'(n_ack - a0), 32'd2);

    // R6: sync notice with a stalled burst
    cfg_wr(3'd1, 32'd128);
    rdy_mode = 2;
    a0 = n_ack; i0 = n_irq;
    send_cmd(4'd5, 32'h3000_0100, 1'b0);
    repeat (2) @(negedge clk);
    pulse_tlb();
    repeat (2) @(negedge clk);
    chk("R6 still busy until burst moves", 32'(busy), 32'd1);
    rdy_mode = 0;
    wait_idle();
    @(negedge clk);
    chk("R6 code sync", 32'(abort_code), 32'd1);
    chk("R6 fault addr", fault_addr, 32'h3000_0120);
    chk("R6 one burst moved", 32'(n_ack - a0), 32'd1);
    chk("R6 no irq", 32'(n_irq - i0), 32'd0);

    // R10: clear
    cfg_wr(3'd4, 32'd0);
    chk("R10 clear code", 32'(abort_code), 32'd0);
    // R6: sync while idle ignored
    pulse_tlb();
    chk("R6 idle sync ignored", 32'(abort_code), 32'd0);
    chk("R6 idle sync busy", 32'(busy), 32'd0);

    // R7: setup faults
    cfg_wr(3'd1, 32'd0);
    send_cmd(4'd5, 32'h4000_0000, 1'b1);
    chk("R7 zero length", 32'(abort_code), 32'd2);
    chk("R7 zero length fault", fault_addr, 32'h4000_0000);
    cfg_wr(3'd1, 32'd40);
    send_cmd(4'd5, 32'h4000_0000, 1'b1);
    chk("R7 odd length", 32'(abort_code), 32'd2);
    cfg_wr(3'd1, 32'd4128);
    send_cmd(4'd5, 32'h4000_0000, 1'b1);
    chk("R7 oversize", 32'(abort_code), 32'd2);
    cfg_wr(3'd1, 32'd64);
    send_cmd(4'd5, 32'h4000_0010, 1'b1);
    chk("R7 misaligned", 32'(abort_code), 32'd2);
    chk("R7 misaligned busy", 32'(busy), 32'd0);
    cfg_wr(3'd0, 32'h0000_0501);
    cfg_wr(3'd3, 32'd0);
    send_cmd(4'd5, 32'h4000_0000, 1'b1);
    chk("R7 zero iterations", 32'(abort_code), 32'd2);

    // R8: double start with stalled burst
    cfg_wr(3'd0, 32'h0000_0500);
    cfg_wr(3'd1, 32'd128);
    rdy_mode = 2;
    send_cmd(4'd5, 32'h4000_0000, 1'b1);
    chk("R10 start clears code", 32'(abort_code), 32'd0);
    send_cmd(4'd5, 32'h4800_0000, 1'b1);
    chk("R8 waits for burst", 32'(busy), 32'd1);
    rdy_mode = 0;
    wait_idle();
    @(negedge clk);
    chk("R8 code double", 32'(abort_code), 32'd3);
    chk("R8 fault addr", fault_addr, 32'h4000_0020);

    // R9: page cross at start
    cfg_wr(3'd1, 32'd256);
    a0 = n_ack;
    send_cmd(4'd5, 32'h5000_0F80, 1'b1);
    chk("R9 start cross code", 32'(abort_code), 32'd4);
    chk("R9 start cross fault", fault_addr, 32'h5000_0F80);
    chk("R9 start cross no burst", 32'(n_ack - a0), 32'd0);

    // R9: page cross at second chained block
    cfg_wr(3'd0, 32'h0000_0501);
    cfg_wr(3'd1, 32'd1024);
    cfg_wr(3'd2, 32'h0000_0E00);
    cfg_wr(3'd3, 32'd3);
    a0 = n_ack; i0 = n_irq;
    send_cmd(4'd5, 32'h6000_0000, 1'b0);
    wait_idle();
    @(negedge clk);
    chk("R9 chain cross code", 32'(abort_code), 32'd4);
    chk("R9 chain cross fault", fault_addr, 32'h6000_0E00);
    chk("R9 chain first block only", 32'(n_ack - a0), 32'd32);
    chk("R9 chain no irq", 32'(n_irq - i0), 32'd0);

    // R11: moving the tag re-selects the block
    cfg_wr(3'd0, 32'h0000_0700);
    cfg_wr(3'd1, 32'd64);
    send_cmd(4'd5, 32'h7000_0000, 1'b1);
    chk("R11 old tag ignored", 32'(busy), 32'd0);
    send_cmd(4'd7, 32'h7000_0000, 1'b1);
    chk("R11 new tag starts", 32'(busy), 32'd1);
    wait_idle();
    @(negedge clk);
    chk("R11 new tag completes", 32'(done), 32'd1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule